// File: doc/BRIEF.md
# Repeated String Move Sequencer

This block copies a run of elements from one region of memory to another without processor help. The caller loads a source offset, a destination offset, an element count, a direction bit and an element-size bit, then pulses start. For each element the engine issues one read at the source offset and waits for the returned data. It then issues one write of that data at the destination offset. After the write is granted it steps both offsets by the element size, up or down, and lowers the count by one. The run ends when the count reaches zero.

The read and write ports each use a request/grant handshake. A request stays up with a stable address until its grant arrives. Read data returns later, on a separate valid strobe. After the run the engine stays idle with the final offsets and the remaining count still on its outputs, so the caller can inspect them or start again from them. A count of zero at start issues no memory access at all.

Top module: `strmove_engine`

## Requirements
- R1: Each granted write lowers the count output by exactly one. After the write that brings the count to zero, done pulses high for one cycle in the following cycle and busy falls.
- R2: With the direction input at 0, both offsets increase after every element. With it at 1, both decrease.
- R3: Every read uses the current source offset as its address, and every write uses the current destination offset. A request held without a grant keeps its address stable in the next cycle.
- R4: Offset arithmetic is modulo 2^16. A step up from 0xFFFF gives 0x0000 (or 0x0001 for a word step from 0xFFFF), and a step down from 0x0000 gives 0xFFFF.
- R5: The offset step is 1 when the size input is 0 (bytes) and 2 when it is 1 (words).
- R6: A start with a count of zero raises done in the cycle after start. No read or write request is issued and busy stays low.
- R7: An element's write request is raised only after its read data has been returned, and the write carries that data unchanged. Read and write requests are never high in the same cycle.
- R8: While idle, the offset and count outputs keep their values from the end of the last run until the next accepted start.
- R9: A start pulse that arrives while busy is high is ignored. The run in progress finishes with its original count, offsets and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | begin a run; accepted only when idle |
| src_i | input | 16 | initial source offset |
| dst_i | input | 16 | initial destination offset |
| cnt_i | input | 16 | number of elements to move |
| down_i | input | 1 | 0 = offsets increase, 1 = offsets decrease |
| word_i | input | 1 | 0 = byte elements, 1 = word elements |
| busy_o | output | 1 | run in progress |
| done_o | output | 1 | one-cycle pulse when a run ends |
| rd_req_o | output | 1 | read request |
| rd_addr_o | output | 16 | read offset |
| rd_word_o | output | 1 | read size, 1 = word |
| rd_gnt_i | input | 1 | read request accepted |
| rd_valid_i | input | 1 | read data valid |
| rd_data_i | input | 16 | returned read data |
| wr_req_o | output | 1 | write request |
| wr_addr_o | output | 16 | write offset |
| wr_word_o | output | 1 | write size, 1 = word |
| wr_data_o | output | 16 | write data |
| wr_gnt_i | input | 1 | write request accepted |
| src_o | output | 16 | current source offset |
| dst_o | output | 16 | current destination offset |
| cnt_o | output | 16 | remaining element count |

## Verification
A wrong offset register shows at the next request. The first read or write address after the fault is off, so a sweep that checks every granted address finds it within one element. A count that steps wrongly shows up as an extra or missing write and as a done pulse in the wrong cycle. A stale data hold shows as write data that does not match what the address-derived read model returned for that element. Any of these appears before the run ends. Wrap faults appear only for runs placed across 0x0000/0xFFFF in both directions and both sizes, so the sweep places runs there.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RDREQ = 2'd1,
      ST_RDWT  = 2'd2,
      ST_WRREQ = 2'd3
   } mv_state_t;
endpackage

// File: rtl/strmove_idx.sv
module strmove_idx #(
   parameter int IDX_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             down_i,
   input  logic             word_i,
   output logic [IDX_W-1:0] nxt_o
);
   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
   localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

   logic [IDX_W-1:0] step;

   generate
      if (IDX_W < 2) begin : g_bad_width
         $error("strmove_idx: IDX_W must be at least 2");
      end
      if (WORD_EN) begin : g_two_sizes
         assign step = word_i ? TWO : ONE;
      end else begin : g_byte_only
         logic unused_word;
         assign unused_word = word_i;
         assign step = ONE;
      end
   endgenerate

   // modulo 2^IDX_W by natural truncation
   assign nxt_o = down_i ? (idx_i - step) : (idx_i + step);
endmodule

// File: rtl/strmove_ctrl.sv
module strmove_ctrl
   import strmove_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cnt_in_zero_i,
   input  logic cnt_last_i,
   input  logic rd_gnt_i,
   input  logic rd_valid_i,
   input  logic wr_gnt_i,
   output logic load_o,
   output logic step_o,
   output logic cap_o,
   output logic rd_req_o,
   output logic wr_req_o,
   output logic busy_o,
   output logic done_o
);
   mv_state_t state_q, state_d;
   logic      done_q, done_d;

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      load_o  = 1'b0;
      step_o  = 1'b0;
      cap_o   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o = 1'b1;
               if (cnt_in_zero_i) done_d = 1'b1;
               else               state_d = ST_RDREQ;
            end
         end
         ST_RDREQ: begin
            if (rd_gnt_i) state_d = ST_RDWT;
         end
         ST_RDWT: begin
            if (rd_valid_i) begin
               cap_o   = 1'b1;
               state_d = ST_WRREQ;
            end
         end
         ST_WRREQ: begin
            if (wr_gnt_i) begin
               step_o = 1'b1;
               if (cnt_last_i) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  state_d = ST_RDREQ;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end

   assign rd_req_o = (state_q == ST_RDREQ);
   assign wr_req_o = (state_q == ST_WRREQ);
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;

   AST_ZERO_COUNT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i && cnt_in_zero_i) |=> (done_o && !busy_o && !rd_req_o && !wr_req_o)); // R6
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o)); // R7
   AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_req_o) |-> $past(rd_valid_i)); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R1
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine #(
   parameter int  IDX_W   = 16,
   parameter int  CNT_W   = 16,
   parameter int  DATA_W  = 16,
   parameter bit  WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  src_i,
   input  logic [IDX_W-1:0]  dst_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              down_i,
   input  logic              word_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              rd_req_o,
   output logic [IDX_W-1:0]  rd_addr_o,
   output logic              rd_word_o,
   input  logic              rd_gnt_i,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_req_o,
   output logic [IDX_W-1:0]  wr_addr_o,
   output logic              wr_word_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_gnt_i,
   output logic [IDX_W-1:0]  src_o,
   output logic [IDX_W-1:0]  dst_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("strmove_engine: CNT_W must be positive");
      end
      if (WORD_EN && DATA_W < 16) begin : g_bad_data
         $error("strmove_engine: word elements need DATA_W >= 16");
      end
   endgenerate

   logic [IDX_W-1:0]  src_q, dst_q, src_nx, dst_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] data_q;
   logic              down_q, word_q;
   logic              load, step, cap;

   strmove_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .cnt_in_zero_i (cnt_i == '0),
      .cnt_last_i    (cnt_q == CNT_ONE),
      .rd_gnt_i      (rd_gnt_i),
      .rd_valid_i    (rd_valid_i),
      .wr_gnt_i      (wr_gnt_i),
      .load_o        (load),
      .step_o        (step),
      .cap_o         (cap),
      .rd_req_o      (rd_req_o),
      .wr_req_o      (wr_req_o),
      .busy_o        (busy_o),
      .done_o        (done_o)
   );

   strmove_idx #(.IDX_W(IDX_W), .WORD_EN(WORD_EN)) u_src_step (
      .idx_i (src_q), .down_i (down_q), .word_i (word_q), .nxt_o (src_nx)
   );
   strmove_idx #(.IDX_W(IDX_W), .WORD_EN(WORD_EN)) u_dst_step (
      .idx_i (dst_q), .down_i (down_q), .word_i (word_q), .nxt_o (dst_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         down_q <= 1'b0;
         word_q <= 1'b0;
      end else if (load) begin
         src_q  <= src_i;
         dst_q  <= dst_i;
         cnt_q  <= cnt_i;
         down_q <= down_i;
         word_q <= WORD_EN ? word_i : 1'b0;
      end else if (step) begin
         src_q  <= src_nx;
         dst_q  <= dst_nx;
         cnt_q  <= cnt_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q <= '0;
      else if (cap) data_q <= rd_data_i;
   end

   assign rd_addr_o = src_q;
   assign wr_addr_o = dst_q;
   assign rd_word_o = word_q;
   assign wr_word_o = word_q;
   assign wr_data_o = data_q;
   assign src_o     = src_q;
   assign dst_o     = dst_q;
   assign cnt_o     = cnt_q;

   AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_gnt_i) |=> (cnt_o == $past(cnt_o) - CNT_ONE)); // R1
   AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o))); // R3
   AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_gnt_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R3
   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o))); // R8
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !(wr_req_o && wr_gnt_i)) |=> ($stable(src_o) && $stable(cnt_o))); // R9
endmodule

// File: tb/test_strmove_engine.sv
module test_strmove_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
   logic        down_i = 1'b0, word_i = 1'b0;
   logic        busy_o, done_o;
   logic        rd_req_o, rd_word_o, wr_req_o, wr_word_o;
   logic [15:0] rd_addr_o, wr_addr_o, wr_data_o;
   logic        rd_gnt_i = 1'b0, rd_valid_i = 1'b0, wr_gnt_i = 1'b0;
   logic [15:0] rd_data_i = '0;
   logic [15:0] src_o, dst_o, cnt_o;

   strmove_engine i_strmove_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .down_i(down_i), .word_i(word_i),
      .busy_o(busy_o), .done_o(done_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_word_o(rd_word_o),
      .rd_gnt_i(rd_gnt_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_word_o(wr_word_o),
      .wr_data_o(wr_data_o), .wr_gnt_i(wr_gnt_i),
      .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
   );

   always #10 clk = ~clk; // 50 MHz

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   // responder state
   int          lat = 0;
   int          rwait = 0, wwait = 0;
   int          n_rd = 0, n_wr = 0;
   logic        rd_pend = 1'b0;
   logic [15:0] pend_addr = '0, last_rd = '0;
   logic [15:0] exp_rd = '0, exp_wr = '0;
   logic        exp_down = 1'b0, exp_word = 1'b0;

   function automatic logic [15:0] mem_f(input logic [15:0] a);
      return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
   endfunction

   function automatic logic [15:0] nxt(input logic [15:0] a, input logic d, input logic w);
      logic [15:0] s;
      s = w ? 16'd2 : 16'd1;
      return d ? a - s : a + s;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
         finish_run();
      end
   end

   // memory model responder, drives at negedge
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req_o && wr_req_o)
            chk(1'b0, "R7 overlap", 32'd1, 32'd0);
         rd_valid_i = 1'b0;
         if (rd_pend) begin
            rd_valid_i = 1'b1;
            rd_data_i  = mem_f(pend_addr);
            rd_pend    = 1'b0;
         end
         if (rd_gnt_i) begin
            rd_gnt_i = 1'b0;
            rd_pend  = 1'b1;
         end else if (rd_req_o) begin
            if (rwait >= lat) begin
               chk(rd_addr_o == exp_rd, "R3 read addr", rd_addr_o, exp_rd);
               chk(rd_word_o == exp_word, "R5 read size", rd_word_o, exp_word);
               pend_addr = rd_addr_o;
               last_rd   = exp_rd;
               exp_rd    = nxt(exp_rd, exp_down, exp_word);
               rd_gnt_i  = 1'b1;
               rwait     = 0;
               n_rd++;
            end else rwait++;
         end
         if (wr_gnt_i) begin
            wr_gnt_i = 1'b0;
         end else if (wr_req_o) begin
            if (wwait >= lat) begin
               chk(wr_addr_o == exp_wr, "R3 write addr", wr_addr_o, exp_wr);
               chk(wr_data_o == mem_f(last_rd), "R7 write data", wr_data_o, mem_f(last_rd));
               exp_wr   = nxt(exp_wr, exp_down, exp_word);
               wr_gnt_i = 1'b1;
               wwait    = 0;
               n_wr++;
            end else wwait++;
         end
      end
   end

   task automatic pulse_start(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                              input logic dn, input logic w);
      @(negedge clk);
      src_i = s; dst_i = d; cnt_i = c; down_i = dn; word_i = w;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // one full run, optionally with an ignored start in the middle (R9)
   task automatic run(input logic [15:0] s, input logic [15:0] d, input int c,
                      input logic dn, input logic w, input bit poke);
      int stp, tot, dcnt;
      logic [15:0] es, ed;
      exp_rd = s; exp_wr = d; exp_down = dn; exp_word = w;
      n_rd = 0; n_wr = 0;
      stp = w ? 2 : 1;
      tot = dn ? -(c * stp) : c * stp;
      es = 16'(int'(s) + tot);
      ed = 16'(int'(d) + tot);
      pulse_start(s, d, 16'(c), dn, w);
      chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
      if (poke) begin
         @(negedge clk);
         src_i = 16'h1234; dst_i = 16'h4321; cnt_i = 16'd7; down_i = ~dn; word_i = ~w;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      dcnt = 0;
      while (!done_o && dcnt < 2000) begin
         @(negedge clk);
         dcnt++;
      end
      chk(done_o == 1'b1, "R1 done seen", done_o, 1);
      chk(busy_o == 1'b0, "R1 idle at done", busy_o, 0);
      chk(n_wr == c, poke ? "R9 element count" : "R1 element count", n_wr, c);
      chk(n_rd == c, "R1 read count", n_rd, c);
      chk(cnt_o == 16'd0, "R1 final count", cnt_o, 0);
      chk(src_o == es, dn ? "R2/R4 final src down" : "R2/R4 final src up", src_o, es);
      chk(dst_o == ed, w ? "R5 final dst word" : "R5 final dst byte", dst_o, ed);
      @(negedge clk);
      chk(done_o == 1'b0, "R1 done one cycle", done_o, 0);
      repeat (3) @(negedge clk);
      chk(src_o == es && dst_o == ed && cnt_o == 16'd0, "R8 held after done", src_o, es);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !rd_req_o && !wr_req_o && cnt_o == 0, "R1 reset state",
          {busy_o, done_o, rd_req_o, wr_req_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 zero count
      exp_rd = 16'h0; exp_wr = 16'h0; n_rd = 0; n_wr = 0;
      @(negedge clk);
      src_i = 16'hABCD; dst_i = 16'h0F0F; cnt_i = 16'd0; down_i = 0; word_i = 1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R6 zero count done", done_o, 1);
      chk(!busy_o && !rd_req_o && !wr_req_o, "R6 zero count no access", {busy_o, rd_req_o, wr_req_o}, 0);
      repeat (4) @(negedge clk);
      chk(n_rd == 0 && n_wr == 0, "R6 no accesses", n_rd + n_wr, 0);
      chk(src_o == 16'hABCD && dst_o == 16'h0F0F && cnt_o == 0, "R8 zero count values", src_o, 16'hABCD);

      // sweep: sizes x directions x counts x latencies, across the wrap point (R2 R4 R5)
      for (int w = 0; w < 2; w++)
         for (int dn = 0; dn < 2; dn++)
            for (int c = 1; c <= 5; c += 2)
               for (int l = 0; l < 3; l += 2) begin
                  lat = l;
                  run(dn ? 16'h0002 : 16'hFFFD, dn ? 16'h0001 : 16'hFFFE, c, dn[0], w[0], 1'b0);
               end

      // R4 exact wrap points
      lat = 0;
      run(16'hFFFF, 16'h0000, 1, 1'b0, 1'b0, 1'b0);
      run(16'h0000, 16'hFFFF, 1, 1'b1, 1'b0, 1'b0);
      run(16'hFFFF, 16'h8000, 2, 1'b0, 1'b1, 1'b0);

      // R9 start ignored while busy
      lat = 1;
      run(16'h2000, 16'h3000, 4, 1'b0, 1'b1, 1'b1);
      run(16'h0101, 16'h0001, 6, 1'b1, 1'b0, 1'b1);

      // R8 back-to-back: next run starts from the held values
      lat = 0;
      run(src_o, dst_o, 3, 1'b1, 1'b1, 1'b0);

      finish_run();
   end
endmodule